// File: doc/BRIEF.md
# One-Time-Programmable Memory Write Sequencer

This block writes a complete data image into a word-organised one-time-programmable memory. After a start request it raises both programming supply levels, gives every word one blind program pulse, then walks the memory a second time. In that walk it compares each word with the expected image and adds pulses, verifying after each one, until the word matches or the per-word retry limit is spent. After a clean walk both supplies drop back to the normal level. The whole memory is then read once more and compared, which gives the final verdict.

The expected image is supplied by the surrounding logic as a combinational lookup on the address the block drives. The memory under programming is modelled inside the block. Its bits can only move from erased (0) to programmed (1). A weak-cell model, driven from ports, can make a range of words need several pulses, or lose their content once the supplies return to normal. Supply control is limited to two digital level flags. Pulse width and settling time are counted in clock cycles.

Top module: `otp_prog_sequencer`

## Requirements
- R1: Reset behaviour and start.
  - After reset, busy, done, pass, fail, the program strobe and both supply flags are 0.
  - A start pulse seen in the idle state sets busy and both supply flags on the next cycle, and clears pass and fail.
- R2: Settling before the first pulse. After each supply-level change the block waits SETTLE_CYC cycles before it pulses or reads. The first program strobe therefore rises SETTLE_CYC+1 cycles after the start cycle.
- R3: Pulse width. Every program strobe pulse is high for exactly PULSE_CYC consecutive cycles.
- R4: Blind pass.
  - The first pass applies exactly one pulse to each address from 0 to DEPTH-1, in that order, with no comparison between pulses.
  - A memory that needs no extra pulses sees exactly DEPTH strobes.
  - Strobes occur only while the raised supply flags are set.
- R5: Verify and retry. In the verify pass, a word that does not match the image gets another pulse and a new comparison. A weak word that needs N pulses in total, with N no greater than 11, still passes after N-1 extra pulses.
- R6: Retry limit. At most 10 extra pulses are applied to one word. If the word still mismatches after that, the run ends with fail = 1 and fail_addr set to that word. The supply flags drop to 0 when the run ends.
- R7: Retry count per word. The retry count restarts at zero whenever the address advances, so several consecutive weak words can each use all 10 extra pulses.
- R8: Final read-back.
  - After a clean verify pass both supply flags go to 0 together, and the block waits SETTLE_CYC cycles.
  - It then reads every word once and compares it with the image. A mismatch ends the run with fail and that address; otherwise pass = 1.
- R9: Completion and held results.
  - done is high for exactly one cycle, and busy is 0 in that cycle.
  - pass, fail and fail_addr stay unchanged until the next start.
  - pass and fail are never both 1.
- R10: Memory bit direction.
  - A pulse can only turn erased bits (0) into programmed bits (1). A programmed bit never returns to 0 in the stored array.
  - An image that asks for a 0 where a 1 is already programmed fails in the verify pass at that address.
- R11: Weak-cell model.
  - A word at an address not below weak_from, with weak_need of 2 or more, takes its data only on its weak_need-th pulse since start. weak_need of 0 or 1 means a normal cell.
  - With weak_leak = 1, those words read as all zeros while the supplies are at the normal level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Launches a programming run when idle |
| img_data | input | WIDTH | Expected image word for img_addr |
| weak_from | input | AW | Lowest address of the weak-cell range |
| weak_need | input | 4 | Pulses a weak word needs (0 or 1: normal) |
| weak_leak | input | 1 | Weak words read as zero at normal supply |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run succeeded, held |
| fail | output | 1 | Run failed, held |
| fail_addr | output | AW | Address of the failing word, held |
| img_addr | output | AW | Current word address |
| pgm_strobe | output | 1 | Program pulse |
| vcc_hi | output | 1 | Raised core supply requested |
| vpp_hi | output | 1 | Raised program supply requested |

## Verification
A fresh memory with a nonzero image checks the nominal path: DEPTH strobes, the settle gap and the length of the normal-supply phase. Reprogramming the same image unchanged shows that the blind pass pulses even words that already match. An altered image asking for a 1-to-0 change tells the bit-direction rule apart from the retry limit, through the failing address and a strobe count of DEPTH+10. A weak range of three words that each need 11 pulses separates a per-word retry count from a shared one. A range that needs 12 pulses checks the cap. A leaking range passes the verify pass but fails the final read, which shows that the last comparison happens at normal supply.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int WEAK_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SET_HI,
    ST_BPULSE,
    ST_BNEXT,
    ST_VERIFY,
    ST_VPULSE,
    ST_SET_LO,
    ST_FINAL,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] lval,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load)                cnt_d = lval;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == CW'(1));

  // expiry without reload leaves the counter empty (pulse/settle length, R3)
  assert_expire_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/otp_cell_model.sv
module otp_cell_model
  import otp_prog_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              pgm,
  input  logic              hv,
  input  logic [AW-1:0]     addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [AW-1:0]     weak_from,
  input  logic [WEAK_W-1:0] weak_need,
  input  logic              weak_leak,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0]  mem_q [DEPTH];
  logic [WIDTH-1:0]  mem_d [DEPTH];
  logic [WEAK_W-1:0] cnt_q [DEPTH];
  logic [WEAK_W-1:0] cnt_d [DEPTH];
  logic              pgm_q;
  logic              rise;
  logic              weak_hit;
  logic [WEAK_W:0]   nth;
  logic              takes;

  assign rise     = pgm && !pgm_q;
  assign weak_hit = (addr >= weak_from);
  assign nth      = {1'b0, cnt_q[addr]} + 1'b1;
  assign takes    = !weak_hit || (weak_need <= WEAK_W'(1)) ||
                    (nth >= {1'b0, weak_need});

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) cnt_d[i] = '0;
    end
    if (rise) begin
      if (!(&cnt_q[addr])) cnt_d[addr] = cnt_q[addr] + 1'b1;
      if (takes)           mem_d[addr] = mem_q[addr] | wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      pgm_q <= pgm;
      if (clr || rise) begin
        mem_q <= mem_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign rdata = (weak_leak && !hv && weak_hit) ? '0 : mem_q[addr];

  // stored bits only move from erased to programmed
  for (genvar g = 0; g < DEPTH; g++) begin : g_mono
    assert_bits_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_q[g] & $past(mem_q[g])) == $past(mem_q[g])));
  end
endmodule

// File: rtl/otp_prog_fsm.sv
module otp_prog_fsm
  import otp_prog_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WIDTH      = 16,
  parameter int PULSE_CYC  = 5,
  parameter int SETTLE_CYC = 3,
  parameter int MAX_RETRY  = 10,
  parameter int TW         = 3,
  localparam int AW        = $clog2(DEPTH),
  localparam int RW        = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] img_data,
  input  logic             expire,
  output logic             tload,
  output logic [TW-1:0]    tval,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             fail,
  output logic [AW-1:0]    fail_addr,
  output logic [AW-1:0]    addr,
  output logic             pgm_strobe,
  output logic             hv
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [RW-1:0] RMAX = RW'(MAX_RETRY);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [RW-1:0] rty_q, rty_d;
  logic          hv_q, hv_d;
  logic          pass_q, pass_d, fail_q, fail_d;
  logic [AW-1:0] fa_q, fa_d;
  logic          res_en;
  logic          match;

  assign match = (rd_data == img_data);

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rty_d  = rty_q;
    hv_d   = hv_q;
    pass_d = pass_q;
    fail_d = fail_q;
    fa_d   = fa_q;
    res_en = 1'b0;
    tload  = 1'b0;
    tval   = TW'(PULSE_CYC);
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_SET_HI;
        addr_d = '0;
        rty_d  = '0;
        hv_d   = 1'b1;
        res_en = 1'b1;
        pass_d = 1'b0;
        fail_d = 1'b0;
        fa_d   = '0;
        tload  = 1'b1;
        tval   = TW'(SETTLE_CYC);
      end
      ST_SET_HI: if (expire) begin
        st_d  = ST_BPULSE;
        tload = 1'b1;
      end
      ST_BPULSE: if (expire) begin
        if (addr_q == LAST) begin
          st_d   = ST_VERIFY;
          addr_d = '0;
        end else begin
          st_d   = ST_BNEXT;
          addr_d = addr_q + 1'b1;
        end
      end
      ST_BNEXT: begin
        st_d  = ST_BPULSE;
        tload = 1'b1;
      end
      ST_VERIFY: begin
        if (match) begin
          rty_d = '0;
          if (addr_q == LAST) begin
            st_d   = ST_SET_LO;
            addr_d = '0;
            hv_d   = 1'b0;
            tload  = 1'b1;
            tval   = TW'(SETTLE_CYC);
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end else if (rty_q == RMAX) begin
          st_d   = ST_DONE;
          hv_d   = 1'b0;
          res_en = 1'b1;
          fail_d = 1'b1;
          fa_d   = addr_q;
        end else begin
          st_d  = ST_VPULSE;
          rty_d = rty_q + 1'b1;
          tload = 1'b1;
        end
      end
      ST_VPULSE: if (expire) st_d = ST_VERIFY;
      ST_SET_LO: if (expire) st_d = ST_FINAL;
      ST_FINAL: begin
        if (!match) begin
          st_d   = ST_DONE;
          res_en = 1'b1;
          fail_d = 1'b1;
          fa_d   = addr_q;
        end else if (addr_q == LAST) begin
          st_d   = ST_DONE;
          res_en = 1'b1;
          pass_d = 1'b1;
        end else begin
          addr_d = addr_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rty_q  <= '0;
      hv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rty_q  <= rty_d;
      hv_q   <= hv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      fa_q   <= '0;
    end else if (res_en) begin
      pass_q <= pass_d;
      fail_q <= fail_d;
      fa_q   <= fa_d;
    end
  end

  assign pgm_strobe = (st_q == ST_BPULSE) || (st_q == ST_VPULSE);
  assign busy       = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done       = (st_q == ST_DONE);
  assign pass       = pass_q;
  assign fail       = fail_q;
  assign fail_addr  = fa_q;
  assign addr       = addr_q;
  assign hv         = hv_q;

  // checker: length of each strobe run
  logic [TW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (pgm_strobe) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgm_strobe) |-> (run_q == TW'(PULSE_CYC)));
  assert_strobe_raised_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_strobe |-> hv_q);
  assert_retry_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rty_q <= RMAX));
  assert_retry_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VERIFY && match && addr_q != LAST) |=> (rty_q == '0));
  assert_final_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FINAL) |-> !hv_q);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !pgm_strobe));
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_q, fail_q}));
endmodule

// File: rtl/otp_prog_sequencer.sv
module otp_prog_sequencer
  import otp_prog_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WIDTH      = 16,
  parameter int PULSE_CYC  = 5,
  parameter int SETTLE_CYC = 3,
  parameter int MAX_RETRY  = 10,
  localparam int AW        = $clog2(DEPTH),
  localparam int TMAX      = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC,
  localparam int TW        = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WIDTH-1:0]  img_data,
  input  logic [AW-1:0]     weak_from,
  input  logic [WEAK_W-1:0] weak_need,
  input  logic              weak_leak,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [AW-1:0]     img_addr,
  output logic              pgm_strobe,
  output logic              vcc_hi,
  output logic              vpp_hi
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             tload, expire, hv;
  logic [TW-1:0]    tval;
  logic [WIDTH-1:0] rd_data;
  logic [AW-1:0]    addr;
  logic             clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign clr = start && !busy && !done;

  otp_cycle_timer #(.CW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (tload),
    .lval   (tval),
    .expire (expire)
  );

  otp_prog_fsm #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .PULSE_CYC(PULSE_CYC),
    .SETTLE_CYC(SETTLE_CYC), .MAX_RETRY(MAX_RETRY), .TW(TW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .rd_data    (rd_data),
    .img_data   (img_data),
    .expire     (expire),
    .tload      (tload),
    .tval       (tval),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .addr       (addr),
    .pgm_strobe (pgm_strobe),
    .hv         (hv)
  );

  otp_cell_model #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cells (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (clr),
    .pgm       (pgm_strobe),
    .hv        (hv),
    .addr      (addr),
    .wdata     (img_data),
    .weak_from (weak_from),
    .weak_need (weak_need),
    .weak_leak (weak_leak),
    .rdata     (rd_data)
  );

  assign img_addr = addr;
  assign vcc_hi   = hv;
  assign vpp_hi   = hv;
endmodule

// File: tb/otp_prog_sequencer_bench.sv
module otp_prog_sequencer_bench;
  localparam int DEPTH  = 16;
  localparam int WIDTH  = 16;
  localparam int PULSE  = 5;
  localparam int SETTLE = 3;
  localparam int AW     = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIDTH-1:0] img_data;
  logic [AW-1:0]    weak_from = '0;
  logic [3:0]       weak_need = '0;
  logic             weak_leak = 1'b0;
  logic             busy, done, pass, fail, pgm_strobe, vcc_hi, vpp_hi;
  logic [AW-1:0]    fail_addr, img_addr;
  bit               img_alt = 1'b0;

  always #5 clk = ~clk;

  otp_prog_sequencer #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PULSE_CYC(PULSE),
                       .SETTLE_CYC(SETTLE), .MAX_RETRY(10)) u_otp_prog_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .img_data(img_data),
    .weak_from(weak_from), .weak_need(weak_need), .weak_leak(weak_leak),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
    .img_addr(img_addr), .pgm_strobe(pgm_strobe), .vcc_hi(vcc_hi), .vpp_hi(vpp_hi)
  );

  function automatic logic [WIDTH-1:0] img_word(input logic [AW-1:0] a, input bit alt);
    logic [3:0]       n;
    logic [WIDTH-1:0] w;
    n = 4'(a);
    w = {n, ~n, n ^ 4'hA, 4'h3};
    if (alt && a == AW'(2)) w = w & ~16'h0001;
    return w;
  endfunction
  assign img_data = img_word(img_addr, img_alt);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct { bit ps; bit fl; int fa; int ns; } exp_t;
  exp_t sb_q[$];
  bit   case_done;

  // monitor
  int cyc = 0, s_cyc = 0, run_str = 0, width = 0, lo_cnt = 0;
  bit first_seen = 1'b0, prev_str = 1'b0, prev_done = 1'b0, active = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (start && !busy && !done) begin
        s_cyc = cyc; run_str = 0; first_seen = 0; lo_cnt = 0; active = 1;
      end
      if (active && cyc == s_cyc + 1)
        chk(busy && vcc_hi && vpp_hi && !pass && !fail, "R1 start raise", busy, 1);
      if (pgm_strobe && !prev_str) begin
        run_str++;
        width = 0;
        if (!first_seen) begin
          chk(cyc - s_cyc == SETTLE + 1, "R2 settle gap", cyc - s_cyc, SETTLE + 1);
          first_seen = 1;
        end
      end
      if (pgm_strobe) width++;
      if (!pgm_strobe && prev_str) chk(width == PULSE, "R3 pulse width", width, PULSE);
      if (busy && !vpp_hi) lo_cnt++;
      if (vcc_hi != vpp_hi) chk(0, "R8 flags differ", vcc_hi, vpp_hi);
      if (prev_done) chk(!done, "R9 done single", done, 0);
      if (done) begin
        exp_t e;
        active = 0;
        if (sb_q.size() == 0) chk(0, "R9 unexpected done", 1, 0);
        else begin
          e = sb_q.pop_front();
          chk(pass == e.ps, "R9 pass", pass, e.ps);
          chk(fail == e.fl, "R6 fail", fail, e.fl);
          if (e.fl) chk(fail_addr == AW'(e.fa), "R6 fail_addr", fail_addr, e.fa);
          chk(run_str == e.ns, "R4 strobe count", run_str, e.ns);
          chk(!busy && !vpp_hi, "R9 done idle", busy, 0);
          if (e.ps) chk(lo_cnt == SETTLE + DEPTH, "R8 normal phase", lo_cnt, SETTLE + DEPTH);
        end
        case_done = 1;
      end
    end
    prev_str  = pgm_strobe;
    prev_done = done;
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(!busy && !done && !pass && !fail && !pgm_strobe && !vcc_hi && !vpp_hi,
        "R1 reset state", {busy, done, pass, fail, pgm_strobe, vcc_hi}, 0);
  endtask

  task automatic run_case(input bit ps, input bit fl, input int fa, input int ns, input string tag);
    exp_t e;
    e.ps = ps; e.fl = fl; e.fa = fa; e.ns = ns;
    sb_q.push_back(e);
    case_done = 0;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    while (!case_done) @(posedge clk);
    repeat (5) @(posedge clk);
    #2;
    chk(pass == ps && fail == fl && !busy && !done, {tag, " R9 held"}, pass, ps);
    if (fl) chk(fail_addr == AW'(fa), {tag, " R9 held addr"}, fail_addr, fa);
  endtask

  initial begin
    do_reset();
    // fresh memory, nonzero image: nominal run
    run_case(1, 0, 0, DEPTH, "R4 fresh");
    // same image again: blind pass still pulses every word
    run_case(1, 0, 0, DEPTH, "R4 reprogram");
    // image wants a 1 to go back to 0 at address 2
    img_alt = 1'b1;
    run_case(0, 1, 2, DEPTH + 10, "R10 one-to-zero");
    img_alt = 1'b0;
    // three weak words, 11 pulses each: per-word retry count (R7, R5, R11)
    do_reset();
    weak_from = AW'(DEPTH - 3); weak_need = 4'd11;
    run_case(1, 0, 0, DEPTH + 30, "R7 R5 R11 weak 11");
    // weak words needing 12 pulses exceed the cap
    do_reset();
    weak_from = AW'(5); weak_need = 4'd12;
    run_case(0, 1, 5, DEPTH + 10, "R6 weak 12");
    // leaking words pass verify, fail final read at normal supply
    do_reset();
    weak_from = AW'(9); weak_need = 4'd0; weak_leak = 1'b1;
    run_case(0, 1, 9, DEPTH, "R8 R11 leak");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule